// File: doc/BRIEF.md
# Voice Waveform Shape Selector

This block turns one voice's phase accumulator into the 12-bit sample that the voice feeds to its amplitude stage. From the 24-bit phase it forms a folded triangle, a ramp and a variable-width square wave. A noise sample that arrives from elsewhere is passed on unchanged. A 4-bit shape select picks one of these shapes, or a combination of several.

Triangle folding can take a second voice's phase into account, which gives ring modulation. A test input forces the square wave high. Combinations without noise are approximated by the bitwise AND of the chosen shapes. Any combination that includes noise is silent.

The result is registered once. An 8-bit readback of its upper bits is registered next to it, so software can observe the shape at a coarser resolution.

Top module: `wave_select`

## Requirements
- R1: While rst_n is low at a rising clock edge, both wave_o and peek_o become zero at that edge.
- R2: wave_o and peek_o are registered. They show the function of the inputs sampled at the previous rising edge and do not change between edges.
- R3: sel_i uses bit 0 = triangle, bit 1 = ramp, bit 2 = square, bit 3 = noise. A value of 0 gives an output of 0x000.
- R4: Triangle (sel_i = 1) outputs acc_i[22:11]. All 12 bits are inverted when the effective fold bit is 1. Without ring modulation, the fold bit is acc_i[23].
- R5: When ring_en_i is high, the fold bit is acc_i[23] XOR src_acc_i[23]. When ring_en_i is low, src_acc_i has no effect.
- R6: Ramp (sel_i = 2) outputs acc_i[23:12].
- R7: Square (sel_i = 4) outputs 0xFFF when acc_i[23:12] >= pw_i, and 0x000 otherwise. Equality gives 0xFFF.
- R8: When test_i is high, the square shape is 0xFFF whatever pw_i and acc_i are.
- R9: Noise alone (sel_i = 8) outputs noise_i.
- R10: Any sel_i with bit 3 set and at least one of bits 2..0 set outputs 0.
- R11: The values 3, 5, 6 and 7 of sel_i output the bitwise AND of the selected triangle, ramp and square shapes.
- R12: peek_o always equals wave_o[11:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_i | input | 24 | This voice's phase accumulator |
| src_acc_i | input | 24 | Modulating voice's phase accumulator |
| pw_i | input | 12 | Square-wave threshold |
| noise_i | input | 12 | Noise sample |
| sel_i | input | 4 | Shape select |
| ring_en_i | input | 1 | Ring modulation enable |
| test_i | input | 1 | Forces the square shape high |
| wave_o | output | 12 | Registered shape output |
| peek_o | output | 8 | Registered upper 8 output bits |

## Verification
Two functions can act in the same cycle: the test override of the square shape, and ring-modulated triangle folding when square and triangle are combined (sel_i = 5). The bench sets test_i together with ring_en_i and a modulating phase whose top bit differs from the voice's own. It does this with a threshold the phase cannot reach. The result must equal the inverted triangle alone, because the forced square passes every bit through the AND. It also checks the same setup with test_i low, where the output must be zero.

// File: rtl/wave_select_pkg.sv
// Package: shared parameters and the shape-select bit positions.
// Assumes: select bits are decoded by position, never as an enumeration.
package wave_select_pkg;
    localparam int ACC_W   = 24;
    localparam int SHAPE_W = 12;
    localparam int PEEK_W  = 8;
    localparam int SEL_W   = 4;

    // Bit positions of the shape select
    localparam int SEL_TRI   = 0;
    localparam int SEL_RAMP  = 1;
    localparam int SEL_SQR   = 2;
    localparam int SEL_NOISE = 3;
    localparam int N_TONAL   = 3;
endpackage

// File: rtl/wave_select_tri.sv
// Module: folded triangle with optional ring modulation.
// Assumes: ACC_W > SHAPE_W + 1; the fold bit is the accumulator MSB.
module wave_select_tri #(
    parameter int ACC_W   = 24,
    parameter int SHAPE_W = 12
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [ACC_W-1:0]   src_acc_i,
    input  logic               ring_en_i,
    output logic [SHAPE_W-1:0] tri_o
);
    localparam int LO = ACC_W - 1 - SHAPE_W;

    logic fold;

    // Fold bit: own MSB, optionally XORed with the modulator MSB
    always_comb begin
        fold  = acc_i[ACC_W-1] ^ (ring_en_i & src_acc_i[ACC_W-1]);
        tri_o = fold ? ~acc_i[ACC_W-2:LO] : acc_i[ACC_W-2:LO];
    end
endmodule

// File: rtl/wave_select_sqr.sv
// Module: ramp and square shapes taken from the accumulator top bits.
// Assumes: the square threshold is unsigned and as wide as the shape.
module wave_select_sqr #(
    parameter int ACC_W   = 24,
    parameter int SHAPE_W = 12
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [SHAPE_W-1:0] pw_i,
    input  logic               test_i,
    output logic [SHAPE_W-1:0] ramp_o,
    output logic [SHAPE_W-1:0] sqr_o
);
    logic [SHAPE_W-1:0] top;

    // Ramp is the top bits; square compares them with the threshold
    always_comb begin
        top    = acc_i[ACC_W-1:ACC_W-SHAPE_W];
        ramp_o = top;
        sqr_o  = (test_i || (top >= pw_i)) ? '1 : '0;
    end
endmodule

// File: rtl/wave_select_mix.sv
// Module: combines the tonal shapes by AND and applies noise rules.
// Assumes: the select bit positions come from wave_select_pkg.
module wave_select_mix
    import wave_select_pkg::*;
#(
    parameter int SHAPE_W = 12
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [SHAPE_W-1:0] tri_i,
    input  logic [SHAPE_W-1:0] ramp_i,
    input  logic [SHAPE_W-1:0] sqr_i,
    input  logic [SHAPE_W-1:0] noise_i,
    output logic [SHAPE_W-1:0] mix_o
);
    logic [SHAPE_W-1:0] shapes [N_TONAL];
    logic [SHAPE_W-1:0] masked [N_TONAL];
    logic [SHAPE_W-1:0] anded;

    assign shapes[SEL_TRI]  = tri_i;
    assign shapes[SEL_RAMP] = ramp_i;
    assign shapes[SEL_SQR]  = sqr_i;

    // Unselected shapes turn into all ones so they drop out of the AND
    for (genvar g = 0; g < N_TONAL; g++) begin : g_mask
        assign masked[g] = sel_i[g] ? shapes[g] : '1;
    end

    // AND across the tonal shapes
    always_comb begin
        anded = '1;
        for (int i = 0; i < N_TONAL; i++) anded &= masked[i];
    end

    // Final pick: silence, tonal AND, noise alone or silenced noise mix
    always_comb begin
        if (sel_i[SEL_NOISE])
            mix_o = (sel_i[N_TONAL-1:0] == '0) ? noise_i : '0;
        else if (sel_i[N_TONAL-1:0] == '0)
            mix_o = '0;
        else
            mix_o = anded;
    end
endmodule

// File: rtl/wave_select.sv
// Module: top of the shape selector; registers the shape and its readback.
// Assumes: synchronous active-low reset; the inputs are stable around clk.
module wave_select
    import wave_select_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int SW = SHAPE_W,
    parameter int PW = PEEK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] src_acc_i,
    input  logic [SW-1:0] pw_i,
    input  logic [SW-1:0] noise_i,
    input  logic [3:0]    sel_i,
    input  logic          ring_en_i,
    input  logic          test_i,
    output logic [SW-1:0] wave_o,
    output logic [PW-1:0] peek_o
);
    logic [SW-1:0] tri_w, ramp_w, sqr_w, mix_w;

    wave_select_tri #(.ACC_W(AW), .SHAPE_W(SW)) u_tri (
        .acc_i(acc_i), .src_acc_i(src_acc_i), .ring_en_i(ring_en_i), .tri_o(tri_w));

    wave_select_sqr #(.ACC_W(AW), .SHAPE_W(SW)) u_sqr (
        .acc_i(acc_i), .pw_i(pw_i), .test_i(test_i), .ramp_o(ramp_w), .sqr_o(sqr_w));

    wave_select_mix #(.SHAPE_W(SW)) u_mix (
        .sel_i(sel_i), .tri_i(tri_w), .ramp_i(ramp_w), .sqr_i(sqr_w),
        .noise_i(noise_i), .mix_o(mix_w));

    // Output register for the full shape
    always_ff @(posedge clk) begin
        if (!rst_n) wave_o <= '0;
        else        wave_o <= mix_w;
    end

    // Separate register for the coarse readback
    always_ff @(posedge clk) begin
        if (!rst_n) peek_o <= '0;
        else        peek_o <= mix_w[SW-1:SW-PW];
    end
endmodule

// File: rtl/wave_select_chk.sv
// Module: assertion checker bound to wave_select.
// Assumes: default widths (24-bit phase, 12-bit shape, 8-bit readback).
module wave_select_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] acc_i,
    input logic [11:0] pw_i,
    input logic [11:0] noise_i,
    input logic [3:0]  sel_i,
    input logic        test_i,
    input logic [11:0] wave_o,
    input logic [7:0]  peek_o
);
    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 |-> wave_o == '0 && peek_o == '0);

    p_sel_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i) == 4'h0 |-> wave_o == 12'h000);

    p_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i) == 4'h2 |-> wave_o == $past(acc_i[23:12]));

    p_test_sqr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i) == 4'h4 && $past(test_i) |-> wave_o == 12'hFFF);

    p_noise_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i) == 4'h8 |-> wave_o == $past(noise_i));

    p_noise_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i[3]) && $past(sel_i[2:0]) != 3'b000 |-> wave_o == '0);

    p_peek_r12: assert property (@(posedge clk) disable iff (!rst_n)
        peek_o == wave_o[11:4]);

    // R7: square follows the threshold comparison
    p_sqr_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_i) == 4'h4 && !$past(test_i) |->
        wave_o == (($past(acc_i[23:12]) >= $past(pw_i)) ? 12'hFFF : 12'h000));
endmodule

bind wave_select wave_select_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .pw_i(pw_i), .noise_i(noise_i),
    .sel_i(sel_i), .test_i(test_i), .wave_o(wave_o), .peek_o(peek_o));

// File: tb/wave_select_test.sv
module wave_select_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] acc_i, src_acc_i;
    logic [11:0] pw_i, noise_i;
    logic [3:0]  sel_i;
    logic        ring_en_i, test_i;
    logic [11:0] wave_o;
    logic [7:0]  peek_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    wave_select uut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .src_acc_i(src_acc_i),
        .pw_i(pw_i), .noise_i(noise_i), .sel_i(sel_i), .ring_en_i(ring_en_i),
        .test_i(test_i), .wave_o(wave_o), .peek_o(peek_o));

    always #4 clk = ~clk;

    function automatic logic [11:0] ref_tri(logic [23:0] a, logic [23:0] s, logic r);
        logic f;
        f = a[23] ^ (r & s[23]);
        return f ? ~a[22:11] : a[22:11];
    endfunction

    function automatic logic [11:0] ref_sqr(logic [23:0] a, logic [11:0] p, logic t);
        return (t || a[23:12] >= p) ? 12'hFFF : 12'h000;
    endfunction

    function automatic logic [11:0] ref_wave(logic [3:0] s);
        logic [11:0] v;
        if (s[3]) return (s[2:0] == 3'b000) ? noise_i : 12'h000;
        if (s == 4'h0) return 12'h000;
        v = 12'hFFF;
        if (s[0]) v &= ref_tri(acc_i, src_acc_i, ring_en_i);
        if (s[1]) v &= acc_i[23:12];
        if (s[2]) v &= ref_sqr(acc_i, pw_i, test_i);
        return v;
    endfunction

    task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, capture at the rising edge, sample just after
    task automatic apply(string tag, logic [3:0] s, logic [11:0] exp);
        @(negedge clk);
        sel_i = s;
        @(posedge clk);
        #1;
        check(tag, wave_o, exp);
        check({tag, " R12 peek"}, {4'h0, peek_o}, {4'h0, exp[11:4]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; acc_i = 24'hABCDEF; sel_i = 4'h2;
        @(posedge clk); #1;
        check("R1 reset wave", wave_o, 12'h000);
        check("R1 reset peek", {4'h0, peek_o}, 12'h000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_latency;
        acc_i = 24'h5A3000;
        apply("R2 captured", 4'h2, 12'h5A3);
        @(negedge clk);
        acc_i = 24'h123000; #1;
        check("R2 held between edges", wave_o, 12'h5A3);
        @(posedge clk); #1;
        check("R2 next edge", wave_o, 12'h123);
    endtask

    task automatic t_zero;
        acc_i = 24'hFFFFFF; noise_i = 12'hFFF;
        apply("R3 select zero", 4'h0, 12'h000);
    endtask

    task automatic t_tri;
        ring_en_i = 1'b0; src_acc_i = 24'h800000;
        acc_i = 24'h3FF800;
        apply("R4 triangle rising", 4'h1, 12'h7FF);
        acc_i = 24'hC00000;
        apply("R4 triangle falling", 4'h1, 12'h7FF);
        acc_i = 24'h000000;
        apply("R5 src ignored without ring", 4'h1, 12'h000);
    endtask

    task automatic t_ring;
        ring_en_i = 1'b1; src_acc_i = 24'h800000;
        acc_i = 24'h000000;
        apply("R5 ring folds low half", 4'h1, 12'hFFF);
        acc_i = 24'hC00000;
        apply("R5 ring unfolds high half", 4'h1, 12'h800);
        ring_en_i = 1'b0;
    endtask

    task automatic t_ramp;
        acc_i = 24'hE4CFFF;
        apply("R6 ramp", 4'h2, 12'hE4C);
    endtask

    task automatic t_sqr;
        test_i = 1'b0; pw_i = 12'h400;
        acc_i = 24'h400000;
        apply("R7 square at threshold", 4'h4, 12'hFFF);
        acc_i = 24'h3FFFFF;
        apply("R7 square below threshold", 4'h4, 12'h000);
        pw_i = 12'h000; acc_i = 24'h000000;
        apply("R7 square zero threshold", 4'h4, 12'hFFF);
    endtask

    task automatic t_test;
        pw_i = 12'hFFF; acc_i = 24'h000000; test_i = 1'b1;
        apply("R8 test forces square", 4'h4, 12'hFFF);
        test_i = 1'b0;
        apply("R8 test released", 4'h4, 12'h000);
    endtask

    task automatic t_noise;
        noise_i = 12'hA5C; acc_i = 24'hFFFFFF; pw_i = 12'h000;
        apply("R9 noise alone", 4'h8, 12'hA5C);
        for (int s = 9; s < 16; s++)
            apply($sformatf("R10 noise mix sel %0d", s), 4'(s), 12'h000);
    endtask

    task automatic t_combo;
        ring_en_i = 1'b0; test_i = 1'b0; pw_i = 12'h300;
        acc_i = 24'h5E7A55;
        for (int s = 3; s < 8; s++) begin
            if (s == 4) continue;
            apply($sformatf("R11 combo sel %0d", s), 4'(s), ref_wave(4'(s)));
        end
        acc_i = 24'h1E7A55;
        apply("R11 combo square low", 4'h6, 12'h000);
    endtask

    // Test override and ring folding act together on square+triangle
    task automatic t_overlap;
        ring_en_i = 1'b1; src_acc_i = 24'h800000; pw_i = 12'hFFF;
        acc_i = 24'h1234AB; test_i = 1'b1;
        apply("R8 R5 overlap", 4'h5, ~acc_i[22:11]);
        test_i = 1'b0;
        apply("R8 R11 overlap released", 4'h5, 12'h000);
        ring_en_i = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; acc_i = '0; src_acc_i = '0; pw_i = '0; noise_i = '0;
        sel_i = '0; ring_en_i = 1'b0; test_i = 1'b0;
        repeat (2) @(posedge clk);
        t_reset;
        t_latency;
        t_zero;
        t_tri;
        t_ring;
        t_ramp;
        t_sqr;
        t_test;
        t_noise;
        t_combo;
        t_overlap;
        finish_run;
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end
endmodule